// File: doc/BRIEF.md
# Misaligned Word Access Splitter

This block sits between a processor's load/store port and a word-wide bus master port that only carries naturally aligned 32-bit transfers. The requester hands it one 32-bit read or write at any byte address and gets back exactly one completion. When the two low address bits are zero, the request goes out unchanged as a single word transfer. Otherwise the block runs two aligned word transfers, one at the containing word and one at the word after it. It merges the returned bytes for a read. For a write, it rotates the data and splits the byte-lane strobes so that each byte lands at its own address.

The block handles one request at a time. It accepts a new request only when idle, and it keeps the bus request steady until the bus completes it. A bus error on either access is reported on the single completion. A failed first access suppresses the second.

Top module: `unaligned_split`

## Requirements
- R1: After reset, req_ready is 1, bus_valid is 0 and rsp_valid is 0.
- R2: A request whose address bits [1:0] are 2'b00 produces exactly one bus transfer, at the request address, with all four strobes set (bus_strb = 4'b1111).
- R3: A request with address offset k = addr[1:0] not zero produces two bus transfers, in this order: the first at addr with bits [1:0] cleared, the second at that address plus 4, wrapping modulo 2^ADDR_W. Every bus address has bits [1:0] equal to 0.
- R4: Read data is little-endian, with byte lane i on bits [8i+7:8i]. Byte j of rsp_rdata (j = 0..3) equals the byte at address addr+j. For k > 0 this means bytes k..3 of the first word followed by bytes 0..k-1 of the second.
- R5: Strobe bit i enables lane i. For a write at offset k > 0, the first transfer enables lanes k..3 and the second enables lanes 0..k-1. Request data byte j is driven on the lane that holds address addr+j.
- R6: Each accepted request yields exactly one rsp_valid pulse, one cycle long. req_ready is 0 from acceptance until the cycle after that pulse, so no second request overlaps the bus transfers of the first.
- R7: rsp_err is 1 when any bus transfer of the request returned bus_err. If the first transfer fails, the second is not issued.
- R8: While bus_valid is 1 and bus_ready is 0, bus_valid, bus_addr, bus_strb, bus_wdata and bus_write hold their values into the next cycle.
- R9: rsp_rdata is 0 for writes and for requests that ended in error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request accepted on req_valid and req_ready |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Byte address, any alignment |
| req_wdata | input | 32 | Write data, byte j for address req_addr+j |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 32 | Read result, valid with rsp_valid |
| rsp_err | output | 1 | Completion carries a bus error |
| bus_valid | output | 1 | Bus transfer requested |
| bus_write | output | 1 | Bus transfer direction |
| bus_addr | output | ADDR_W | Word-aligned bus address |
| bus_wdata | output | 32 | Bus write data, lane-placed |
| bus_strb | output | 4 | Byte-lane enables |
| bus_ready | input | 1 | Transfer completes this cycle |
| bus_rdata | input | 32 | Read data, valid with bus_ready |
| bus_err | input | 1 | Transfer failed, valid with bus_ready |

## Verification
The bench runs reads and writes at all four offsets against a byte-addressed bus model that inserts random wait states. It compares each result against a reference byte memory kept by the bench. Offset zero tells the single-transfer path apart from the split path. Offsets 1, 2 and 3 each exercise a different lane rotation and strobe split, so a wrong shift amount or a lane swapped between the two words shows up. A request straddling the top of the address space checks that the second address wraps. An injected error on the first word, and separately on the second word, shows whether the second access is suppressed and whether the flag reaches the requester, including how much of a failed write still lands.

// File: rtl/unaligned_split.sv
`timescale 1ns/1ps
module unaligned_split #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic              bus_valid,
  output logic              bus_write,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [31:0]       bus_wdata,
  output logic [3:0]        bus_strb,
  input  logic              bus_ready,
  input  logic [31:0]       bus_rdata,
  input  logic              bus_err
);
  localparam int WA_W = ADDR_W - 2;

  typedef enum logic [1:0] {IDLE, FIRST, SECOND, DONE} st_t;
  st_t st;

  logic [WA_W-1:0] wbase;
  logic [1:0]      off;
  logic            wr, err;
  logic [31:0]     wrot, lo, merged, rot_in;
  logic [23:0]     hi;
  logic [3:0]      fstrb;

  always_comb begin
    case (req_addr[1:0])
      2'd1:    rot_in = {req_wdata[23:0], req_wdata[31:24]};
      2'd2:    rot_in = {req_wdata[15:0], req_wdata[31:16]};
      2'd3:    rot_in = {req_wdata[7:0],  req_wdata[31:8]};
      default: rot_in = req_wdata;
    endcase
  end

  always_comb begin
    case (off)
      2'd1:    merged = {hi[7:0],  lo[31:8]};
      2'd2:    merged = {hi[15:0], lo[31:16]};
      2'd3:    merged = {hi[23:0], lo[31:24]};
      default: merged = lo;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= IDLE;
      wbase <= '0;
      off   <= 2'd0;
      wr    <= 1'b0;
      err   <= 1'b0;
      wrot  <= '0;
      lo    <= '0;
      hi    <= '0;
    end else begin
      case (st)
        IDLE: if (req_valid) begin
          wbase <= req_addr[ADDR_W-1:2];
          off   <= req_addr[1:0];
          wr    <= req_write;
          wrot  <= rot_in;
          err   <= 1'b0;
          st    <= FIRST;
        end
        FIRST: if (bus_ready) begin
          lo  <= bus_rdata;
          err <= bus_err;
          st  <= (bus_err || off == 2'd0) ? DONE : SECOND;
        end
        SECOND: if (bus_ready) begin
          hi  <= bus_rdata[23:0];
          err <= bus_err;
          st  <= DONE;
        end
        default: st <= IDLE;
      endcase
    end
  end

  assign fstrb     = 4'b1111 << off;
  assign req_ready = (st == IDLE);
  assign bus_valid = (st == FIRST) || (st == SECOND);
  assign bus_write = wr;
  assign bus_wdata = wrot;
  assign bus_addr  = {(st == SECOND) ? wbase + 1'b1 : wbase, 2'b00};
  assign bus_strb  = (st == SECOND) ? ~fstrb : fstrb;
  assign rsp_valid = (st == DONE);
  assign rsp_err   = err;
  assign rsp_rdata = (wr || err) ? 32'd0 : merged;
endmodule

module unaligned_split_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              bus_valid,
  input logic              bus_ready,
  input logic              bus_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [3:0]        bus_strb
);
  a_r3_bus_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_addr[1:0] == 2'b00);

  a_r5_strobe_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid |-> bus_strb != 4'b0000);

  a_r8_hold_while_wait: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_strb)
      && $stable(bus_wdata) && $stable(bus_write));

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r6_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready);

  a_r6_no_bus_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_valid);

  a_r6_ready_after_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready);
endmodule

bind unaligned_split unaligned_split_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/unaligned_split_test.sv
`timescale 1ns/1ps
module unaligned_split_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        bus_valid, bus_write;
  logic [31:0] bus_addr, bus_wdata;
  logic [3:0]  bus_strb;
  logic        bus_ready = 1'b0, bus_err = 1'b0;
  logic [31:0] bus_rdata = '0;

  unaligned_split #(.ADDR_W(32)) uut (.*);

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  logic [7:0]  mem [256];
  logic [7:0]  ref_m [256];
  int          err_word = -1;
  int          xn;
  logic [31:0] xa [2];
  logic [3:0]  xs [2];

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus model: decides completion at negedge while the request is stable
  initial begin
    forever begin
      @(negedge clk);
      bus_ready = 1'b0;
      bus_err   = 1'b0;
      if (bus_valid) begin
        logic [7:0] b;
        b = {bus_addr[7:2], 2'b00};
        bus_rdata = {mem[8'(b+3)], mem[8'(b+2)], mem[8'(b+1)], mem[b]};
        if ($urandom_range(0, 2) != 0) begin
          bus_ready = 1'b1;
          bus_err   = (int'(bus_addr[7:2]) == err_word);
          if (xn < 2) begin
            xa[xn] = bus_addr;
            xs[xn] = bus_strb;
          end
          xn++;
          if (bus_write && !bus_err)
            for (int i = 0; i < 4; i++)
              if (bus_strb[i]) mem[8'(b+i)] = bus_wdata[8*i +: 8];
        end
      end
    end
  end

  task automatic do_req(input bit w, input logic [31:0] a, input logic [31:0] d);
    int k, w0, w1, en, guard;
    bit e0, e1;
    logic [31:0] base, exp_rd;
    logic [3:0] s0;
    k  = int'(a[1:0]);
    w0 = int'(a[7:2]);
    w1 = (w0 + 1) % 64;
    e0 = (w0 == err_word);
    e1 = (k != 0) && !e0 && (w1 == err_word);
    en = (k == 0 || e0) ? 1 : 2;
    base = {a[31:2], 2'b00};
    s0 = 4'b0000;
    for (int i = 0; i < 4; i++) if (i >= k) s0[i] = 1'b1;
    exp_rd = '0;
    for (int j = 0; j < 4; j++) exp_rd[8*j +: 8] = ref_m[8'(a[7:0] + j)];
    if (w)
      for (int j = 0; j < 4; j++) begin
        bit first;
        first = (j < 4 - k);
        if ((first && !e0) || (!first && !e0 && !e1))
          ref_m[8'(a[7:0] + j)] = d[8*j +: 8];
      end

    @(negedge clk);
    xn = 0;
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    guard = 0;
    while (!rsp_valid && guard < 200) begin
      check(!req_ready, "R6 busy", 32'(req_ready), 32'd0);
      @(negedge clk);
      guard++;
    end
    check(rsp_valid, "R6 response", 32'(rsp_valid), 32'd1);
    check(xn == en, k == 0 ? "R2 transfer count" : "R3/R7 transfer count", 32'(xn), 32'(en));
    check(rsp_err == (e0 || e1), "R7 error flag", 32'(rsp_err), 32'(e0 || e1));
    if (xn >= 1) begin
      check(xa[0] == base, k == 0 ? "R2 address" : "R3 first address", xa[0], base);
      check(xs[0] == s0, k == 0 ? "R2 strobe" : "R5 first strobe", 32'(xs[0]), 32'(s0));
    end
    if (xn >= 2 && en == 2) begin
      check(xa[1] == base + 32'd4, "R3 second address", xa[1], base + 32'd4);
      check(xs[1] == ~s0, "R5 second strobe", 32'(xs[1]), 32'(~s0));
    end
    if (w || e0 || e1)
      check(rsp_rdata == 32'd0, "R9 rdata zero", rsp_rdata, 32'd0);
    else
      check(rsp_rdata == exp_rd, "R4 read merge", rsp_rdata, exp_rd);
    @(negedge clk);
    check(!rsp_valid && req_ready, "R6 single pulse and ready", {rsp_valid, req_ready}, 32'd1);
  endtask

  task automatic verify_bytes(input logic [31:0] a, input string tag);
    logic [31:0] e;
    for (int j = 0; j < 4; j++) e[8*j +: 8] = ref_m[8'(a[7:0] + j)];
    err_word = -1;
    do_req(1'b0, a, 32'd0);
    for (int j = 0; j < 4; j++) check(mem[8'(a[7:0] + j)] == e[8*j +: 8], tag, 32'(mem[8'(a[7:0] + j)]), 32'(e[8*j +: 8]));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'($urandom);
      ref_m[i] = mem[i];
    end
    repeat (3) @(negedge clk);
    check(req_ready && !bus_valid && !rsp_valid, "R1 reset state",
          {req_ready, bus_valid, rsp_valid}, 32'b100);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !bus_valid && !rsp_valid, "R1 after reset release",
          {req_ready, bus_valid, rsp_valid}, 32'b100);

    // directed: every offset, read and write
    for (int k = 0; k < 4; k++) begin
      do_req(1'b0, 32'h0000_0040 + 32'(k), 32'd0);
      do_req(1'b1, 32'h0000_0080 + 32'(k), 32'hA1B2_C3D4);
      verify_bytes(32'h0000_0080 + 32'(k), "R5 write placement");
    end
    // R3 address wrap at the top of the space
    do_req(1'b0, 32'hFFFF_FFFD, 32'd0);
    do_req(1'b1, 32'hFFFF_FFFE, 32'h1122_3344);
    verify_bytes(32'hFFFF_FFFE, "R3 wrap write");
    // R7 first access fails: second skipped, nothing written
    err_word = 5;
    do_req(1'b1, 32'h0000_0015, 32'hDEAD_BEEF);
    verify_bytes(32'h0000_0015, "R7 first-fail write");
    err_word = 5;
    do_req(1'b0, 32'h0000_0016, 32'd0);
    // R7 second access fails: first part still written
    err_word = 9;
    do_req(1'b1, 32'h0000_0023, 32'hCAFE_F00D);
    verify_bytes(32'h0000_0023, "R7 second-fail write");
    err_word = 9;
    do_req(1'b0, 32'h0000_0021, 32'd0);
    err_word = 9;
    do_req(1'b0, 32'h0000_0024, 32'd0);

    // constrained random
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      a = $urandom;
      if ($urandom_range(0, 7) == 0)
        err_word = int'(a[7:2]) + int'($urandom_range(0, 1));
      else
        err_word = -1;
      if (err_word == 64) err_word = 0;
      do_req(1'($urandom_range(0, 1)), a, $urandom);
    end
    err_word = -1;
    for (int i = 0; i < 256; i++)
      if (mem[i] != ref_m[i]) check(1'b0, "R5 final memory image", 32'(mem[i]), 32'(ref_m[i]));

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule